// File: doc/BRIEF.md
# Shared Exclusive-Access Reservation Monitor

This block is the system-wide half of a load-exclusive / store-exclusive scheme for a cluster of `NCORE` processor cores. It keeps one reservation entry per core. Each entry is a state (Open or Exclusive) plus the full address that was reserved. The block takes at most one access per cycle. An access names the issuing core, its kind and its address. For every store-exclusive it returns a registered pass/fail flag one cycle later.

A load-exclusive reserves an address for its core. Any plain store drops every live reservation. A store-exclusive passes only if the requester still holds an exact reservation on that address. A pass drops the reservations of the other cores whose address falls in the same coarse granule. A per-core fail counter forces one deliberate failure after every `FAIL_MAX` successful matches, so that software retry loops get exercised the way a cache eviction would exercise them. A per-core deregister input clears that core's entry and withdraws it from broadcasts until it issues a new load-exclusive.

Top module: `excl_global_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, every entry returns to Open with a zero tag, every fail counter returns to 0, and `resp_valid` and `resp_ok` are 0.
- R2: `req_kind` encodes 0 = idle, 1 = load-exclusive, 2 = plain store, 3 = store-exclusive. `resp_valid` is 1 in exactly the cycle after a store-exclusive request. `resp_ok` is 0 whenever `resp_valid` is 0.
- R3: A load-exclusive from core c sets c's entry to Exclusive, tags it with the full `req_addr`, and makes c a participant in broadcasts.
- R4: A plain store from any core, at any address, clears every Exclusive entry to Open, the issuing core's own entry included.
- R5: A store-exclusive passes only if the requester's entry is Exclusive, its tag equals `req_addr` on all `AW` bits, and no forced failure is due. An exact match clears the requester's entry whether or not the request passes.
- R6: A store-exclusive that finds the requester Open, or finds a tag that differs from `req_addr`, fails and leaves the requester's entry unchanged.
- R7: Each core's fail counter advances on every exact-match store-exclusive from that core. A match that arrives with the counter already at `FAIL_MAX` (default 9) reports failure and resets the counter to 0. From reset, the first 9 matches of a core pass and the 10th fails.
- R8: A passing store-exclusive clears every other Exclusive entry whose tag equals `req_addr` on bits `AW-1:GRAN_LSB` (default 16-byte granules). Entries in other granules stay Exclusive.
- R9: A failing store-exclusive leaves every other core's entry unchanged.
- R10: `dereg[c]` high at an edge clears core c's entry and ends its participation. This takes priority over a request from c in that cycle, and such a request cannot pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_kind | input | 2 | Access kind (0 idle, 1 load-excl, 2 store, 3 store-excl) |
| req_core | input | $clog2(NCORE) | Issuing core index |
| req_addr | input | AW | Access address |
| dereg | input | NCORE | Per-core deregister strobe |
| resp_valid | output | 1 | Store-exclusive result present |
| resp_ok | output | 1 | Store-exclusive passed |

## Verification
The assertions assume that `req_core` is below `NCORE` and that `req_kind` is always one of the four encoded values. Under those assumptions each cycle carries at most one access. The bench drives only defined kinds and core indices 0 to 3. It changes inputs on the falling edge so every rising edge sees settled values. It raises `dereg` only in cycles that it checks separately, so the assertions about one core's entry never see a conflicting strobe unannounced.

// File: rtl/excl_mon_pkg.sv
// Shared types for the exclusive-access reservation monitor.
// Assumes: request kinds use a two-bit encoding fixed at the block's ports.
package excl_mon_pkg;

    typedef enum logic [1:0] {
        KIND_IDLE = 2'd0,
        KIND_LDX  = 2'd1,
        KIND_ST   = 2'd2,
        KIND_STX  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        RSV_OPEN = 1'b0,
        RSV_EXCL = 1'b1
    } rsv_state_e;

endpackage

// File: rtl/excl_mon_decode.sv
// Request decoder: turns the single incoming access into per-core strobes.
// Assumes: req_core < NCORE; one access per cycle.
module excl_mon_decode #(
    parameter int NCORE = 4,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic [1:0]       req_kind,
    input  logic [CW-1:0]    req_core,
    output logic [NCORE-1:0] ldx_own,
    output logic [NCORE-1:0] stx_own,
    output logic             st_any,
    output logic             stx_req
);
    import excl_mon_pkg::*;

    acc_kind_e kind;

    // Classify the access kind.
    always_comb begin
        kind    = acc_kind_e'(req_kind);
        st_any  = (kind == KIND_ST);
        stx_req = (kind == KIND_STX);
    end

    // Per-core select strobes, one pair per core.
    for (genvar gi = 0; gi < NCORE; gi++) begin : g_sel
        localparam logic [CW-1:0] IDX = CW'(gi);
        assign ldx_own[gi] = (kind == KIND_LDX) && (req_core == IDX);
        assign stx_own[gi] = (kind == KIND_STX) && (req_core == IDX);
    end

endmodule

// File: rtl/excl_mon_entry.sv
// One core's reservation entry: state, tag, participation flag and the
// forced-failure counter. Reports a grant when its core's store-exclusive
// matches and no forced failure is due.
// Assumes: at most one of ldx_i / st_any_i / stx_i / snoop_win_i per cycle.
module excl_mon_entry #(
    parameter int AW       = 16,
    parameter int GRAN_LSB = 4,
    parameter int FAIL_MAX = 9,
    localparam int CNTW = $clog2(FAIL_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dereg_i,
    input  logic          ldx_i,
    input  logic          st_any_i,
    input  logic          stx_i,
    input  logic          snoop_win_i,
    input  logic [AW-1:0] addr_i,
    output logic          excl_o,
    output logic [AW-1:0] tag_o,
    output logic          grant_o
);
    import excl_mon_pkg::*;

    rsv_state_e    state_q;
    logic [AW-1:0] tag_q;
    logic          member_q;
    logic [CNTW-1:0] cnt_q;
    logic          own_match;
    logic          fail_due;
    logic          gran_hit;

    // Match conditions for the requester path and the snoop path.
    always_comb begin
        own_match = stx_i && !dereg_i && (state_q == RSV_EXCL) && (tag_q == addr_i);
        fail_due  = (cnt_q >= CNTW'(FAIL_MAX));
        gran_hit  = (tag_q[AW-1:GRAN_LSB] == addr_i[AW-1:GRAN_LSB]);
        grant_o   = own_match && !fail_due;
        excl_o    = (state_q == RSV_EXCL);
        tag_o     = tag_q;
    end

    // Reservation state, tag and participation update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RSV_OPEN;
            tag_q    <= '0;
            member_q <= 1'b0;
        end else if (dereg_i) begin
            state_q  <= RSV_OPEN;
            tag_q    <= '0;
            member_q <= 1'b0;
        end else if (ldx_i) begin
            state_q  <= RSV_EXCL;
            tag_q    <= addr_i;
            member_q <= 1'b1;
        end else if (st_any_i && member_q && state_q == RSV_EXCL) begin
            state_q <= RSV_OPEN;
            tag_q   <= '0;
        end else if (own_match) begin
            state_q <= RSV_OPEN;
            tag_q   <= '0;
        end else if (snoop_win_i && member_q && state_q == RSV_EXCL && gran_hit) begin
            state_q <= RSV_OPEN;
            tag_q   <= '0;
        end
    end

    // Forced-failure counter: wraps to zero on the match that fails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (own_match) begin
            cnt_q <= fail_due ? '0 : cnt_q + 1'b1;
        end
    end

    assert_excl_member_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RSV_EXCL) |-> member_q);
    assert_dereg_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dereg_i |=> (!excl_o && !member_q));
    assert_ldx_reserves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ldx_i && !dereg_i) |=> (excl_o && tag_o == $past(addr_i)));
    assert_store_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_any_i && !dereg_i) |=> !excl_o);
    assert_miss_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_i && !dereg_i && excl_o && tag_o != addr_i) |=> (excl_o && $stable(tag_o)));
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(FAIL_MAX));
    assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        own_match |=> !excl_o);

endmodule

// File: rtl/excl_global_monitor.sv
// System-wide exclusive monitor: one reservation entry per core, one access
// per cycle, registered pass/fail result for every store-exclusive. A pass
// invalidates other cores' reservations in the same address granule.
// Assumes: req_core < NCORE; req_kind holds one of the four encodings.
module excl_global_monitor #(
    parameter int NCORE    = 4,
    parameter int AW       = 16,
    parameter int GRAN_LSB = 4,
    parameter int FAIL_MAX = 9,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_kind,
    input  logic [CW-1:0]    req_core,
    input  logic [AW-1:0]    req_addr,
    input  logic [NCORE-1:0] dereg,
    output logic             resp_valid,
    output logic             resp_ok
);
    logic [NCORE-1:0]         ldx_own;
    logic [NCORE-1:0]         stx_own;
    logic                     st_any;
    logic                     stx_req;
    logic [NCORE-1:0]         grant;
    logic [NCORE-1:0]         excl;
    logic [NCORE-1:0][AW-1:0] tag;
    logic                     stx_win;

    excl_mon_decode #(.NCORE(NCORE)) u_decode (
        .req_kind (req_kind),
        .req_core (req_core),
        .ldx_own  (ldx_own),
        .stx_own  (stx_own),
        .st_any   (st_any),
        .stx_req  (stx_req)
    );

    // A pass is granted by exactly the requesting entry.
    assign stx_win = |grant;

    for (genvar gi = 0; gi < NCORE; gi++) begin : g_entry
        excl_mon_entry #(
            .AW       (AW),
            .GRAN_LSB (GRAN_LSB),
            .FAIL_MAX (FAIL_MAX)
        ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .dereg_i     (dereg[gi]),
            .ldx_i       (ldx_own[gi]),
            .st_any_i    (st_any),
            .stx_i       (stx_own[gi]),
            .snoop_win_i (stx_win && !stx_own[gi]),
            .addr_i      (req_addr),
            .excl_o      (excl[gi]),
            .tag_o       (tag[gi]),
            .grant_o     (grant[gi])
        );

        assert_snoop_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (stx_win && !stx_own[gi] && !dereg[gi] && excl[gi] &&
             tag[gi][AW-1:GRAN_LSB] == req_addr[AW-1:GRAN_LSB]) |=> !excl[gi]);
        assert_fail_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (stx_req && !stx_win && !stx_own[gi] && !dereg[gi] && excl[gi])
            |=> (excl[gi] && $stable(tag[gi])));
    end

    // Registered store-exclusive response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
        end else begin
            resp_valid <= stx_req;
            resp_ok    <= stx_win;
        end
    end

    assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_ok_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ok |-> resp_valid);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stx_req |=> resp_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stx_req |=> !resp_valid);

endmodule

// File: tb/excl_global_monitor_tb.sv
`timescale 1ns/1ps
module excl_global_monitor_tb_top;

    localparam int NCORE = 4;
    localparam int AW    = 16;

    typedef struct packed {
        logic [3:0]  dr;
        logic [1:0]  kind;
        logic [1:0]  core;
        logic [15:0] addr;
        logic        ok;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{4'h0, 2'd1, 2'd0, 16'h0100, 1'b0},  // R3 reserve
        '{4'h0, 2'd3, 2'd0, 16'h0100, 1'b1},  // R5 pass
        '{4'h0, 2'd3, 2'd0, 16'h0100, 1'b0},  // R5 entry cleared -> R6 open fails
        '{4'h0, 2'd1, 2'd1, 16'h0200, 1'b0},
        '{4'h0, 2'd1, 2'd2, 16'h0208, 1'b0},
        '{4'h0, 2'd3, 2'd1, 16'h0200, 1'b1},  // R8 pass kills core2 (same granule)
        '{4'h0, 2'd3, 2'd2, 16'h0208, 1'b0},  // R8
        '{4'h0, 2'd1, 2'd3, 16'h0300, 1'b0},
        '{4'h0, 2'd2, 2'd0, 16'h0500, 1'b0},  // R4 store elsewhere
        '{4'h0, 2'd3, 2'd3, 16'h0300, 1'b0},  // R4
        '{4'h0, 2'd1, 2'd1, 16'h0400, 1'b0},
        '{4'h0, 2'd3, 2'd1, 16'h0404, 1'b0},  // R6 mismatch
        '{4'h0, 2'd3, 2'd1, 16'h0400, 1'b1},  // R6 entry kept
        '{4'h0, 2'd1, 2'd2, 16'h0600, 1'b0},
        '{4'h0, 2'd1, 2'd3, 16'h0610, 1'b0},
        '{4'h0, 2'd3, 2'd2, 16'h0600, 1'b1},
        '{4'h0, 2'd3, 2'd3, 16'h0610, 1'b1},  // R8 other granule survives
        '{4'h0, 2'd1, 2'd0, 16'h0700, 1'b0},
        '{4'h0, 2'd1, 2'd1, 16'h0700, 1'b0},
        '{4'h0, 2'd3, 2'd0, 16'h0708, 1'b0},  // R9 failing request
        '{4'h0, 2'd3, 2'd1, 16'h0700, 1'b1},  // R9 core1 unaffected
        '{4'h0, 2'd3, 2'd0, 16'h0700, 1'b0},  // R8 core0 killed by core1
        '{4'h0, 2'd1, 2'd2, 16'h0800, 1'b0},
        '{4'h4, 2'd0, 2'd0, 16'h0000, 1'b0},  // R10 deregister core2
        '{4'h0, 2'd3, 2'd2, 16'h0800, 1'b0},  // R10
        '{4'h0, 2'd2, 2'd2, 16'h0800, 1'b0}   // R2 plain store: no response
    };

    logic             clk;
    logic             rst_n;
    logic [1:0]       req_kind;
    logic [1:0]       req_core;
    logic [AW-1:0]    req_addr;
    logic [NCORE-1:0] dereg;
    logic             resp_valid;
    logic             resp_ok;

    int n_chk;
    int n_bad;
    int cyc;

    excl_global_monitor #(.NCORE(NCORE), .AW(AW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_kind   (req_kind),
        .req_core   (req_core),
        .req_addr   (req_addr),
        .dereg      (dereg),
        .resp_valid (resp_valid),
        .resp_ok    (resp_ok)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual valid/ok=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge; the response is visible one edge later.
    task automatic step(input logic [3:0] dr, input logic [1:0] kind,
                        input logic [1:0] core, input logic [15:0] addr);
        dereg    = dr;
        req_kind = kind;
        req_core = core;
        req_addr = addr;
        @(posedge clk);
        @(negedge clk);
        dereg    = '0;
        req_kind = 2'd0;
    endtask

    task automatic stx(input logic [1:0] core, input logic [15:0] addr,
                       input logic exp_ok, input string req);
        step(4'h0, 2'd3, core, addr);
        check(req, {resp_valid, resp_ok}, {1'b1, exp_ok});
    endtask

    initial begin
        n_chk = 0; n_bad = 0; cyc = 0;
        rst_n = 1'b0; dereg = '0; req_kind = 2'd0; req_core = '0; req_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {resp_valid, resp_ok}, 2'b00);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].dr, TBL[i].kind, TBL[i].core, TBL[i].addr);
            check($sformatf("R2/R3-R10 vec%0d", i), {resp_valid, resp_ok},
                  (TBL[i].kind == 2'd3) ? {1'b1, TBL[i].ok} : 2'b00);
        end

        // R1: reset drops a live reservation
        step(4'h0, 2'd1, 2'd0, 16'h0A00);
        rst_n = 1'b0;
        step(4'h0, 2'd0, 2'd0, 16'h0000);
        check("R1", {resp_valid, resp_ok}, 2'b00);
        rst_n = 1'b1;
        stx(2'd0, 16'h0A00, 1'b0, "R1");

        // R7: forced failure on the tenth match, R9: other core unaffected
        for (int k = 0; k < 10; k++) begin
            step(4'h0, 2'd1, 2'd3, 16'h0900);
            if (k == 9) step(4'h0, 2'd1, 2'd1, 16'h0900);
            stx(2'd3, 16'h0900, (k < 9), "R7");
        end
        stx(2'd1, 16'h0900, 1'b1, "R9");
        step(4'h0, 2'd1, 2'd3, 16'h0900);
        stx(2'd3, 16'h0900, 1'b1, "R7");

        // R4: a plain store clears the issuer's own reservation
        step(4'h0, 2'd1, 2'd2, 16'h0B00);
        step(4'h0, 2'd2, 2'd2, 16'hFFF0);
        check("R4", {resp_valid, resp_ok}, 2'b00);
        stx(2'd2, 16'h0B00, 1'b0, "R4");

        // R10: deregister wins over a same-cycle store-exclusive
        step(4'h0, 2'd1, 2'd0, 16'h0C00);
        step(4'h1, 2'd3, 2'd0, 16'h0C00);
        check("R10", {resp_valid, resp_ok}, 2'b10);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule